// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block connects a host to a raw 8-bit NAND flash device through one 32-bit memory-mapped register. Each host write to the register names an operation in a 3-bit field, asks for chip enable with one flag bit, and carries one data byte. The bridge turns each write into a flash cycle on the pins: a command latch, an address latch or a data write. It can also store a mode change without starting a flash cycle.

A write with the read operation does not touch the flash. It arms read mode. While read mode is armed, every host read of the register runs one flash read-enable cycle and returns the captured byte. A 16-bit word is therefore fetched as two back-to-back byte reads. Every register read also reports the flash busy state, taken from the ready/busy pin after a two-flop synchroniser. The host bus is held not-ready until the flash cycle in progress has finished.

Strobe timing is set by three parameters, each counted in system clocks: setup (default 2), pulse width (default 3) and hold (default 2). The host handshake works as follows. `host_req` stays high, together with `host_we` and `host_wdata`, until `host_ready` has pulsed for one clock.

Top module: `nand_reg_bridge`

## Requirements
- R1: While reset is active, and after it until the first access, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle` and `nand_ale` are 0, `nand_dq_oe` is 0 and read mode is disarmed.
- R2: Every register write, whatever its opcode, sets `nand_ce_n` to the inverse of write-data bit 31. `nand_ce_n` keeps that value until the next write.
- R3: A write with opcode 0 in bits 30:28 drives bits 23:16 onto `nand_dq_o` with `nand_cle` high and `nand_ale` low, and produces exactly one low pulse on `nand_we_n`.
- R4: A write with opcode 1 drives bits 23:16 with `nand_ale` high and `nand_cle` low, and produces exactly one `nand_we_n` pulse.
- R5: In every flash cycle, `nand_dq_oe` and the latch line are valid SETUP_CLKS clocks before the strobe falls. The strobe stays low for PULSE_CLKS clocks. Data is held HOLD_CLKS clocks after the strobe rises. `nand_cle` and `nand_ale` are never high together, and `nand_we_n` and `nand_re_n` are never low together.
- R6: A write with opcode 3 and bit 31 set produces one data write cycle of bits 23:16, with `nand_cle` and `nand_ale` low. With bit 31 clear, it produces no flash cycle.
- R7: A write with opcode 2 produces no flash cycle and arms read mode. Each host read while armed produces one `nand_re_n` pulse and returns the captured byte in bits 23:16. Successive reads return successive flash bytes in order.
- R8: Read mode stays armed until the next register write of any opcode. A host read while disarmed produces no flash cycle and returns the last captured byte.
- R9: Read-data bit 15 is 1 when `nand_rb_n` is low (busy). It follows the pin through two clock stages, so a change shows after the second rising edge and not after the first. Bits 31:24 and 14:0 read as 0.
- R10: Writes with opcodes 4 to 7 start no flash cycle and leave read mode disarmed. They only update chip enable.
- R11: `host_ready` is a single-clock pulse that ends every access. An access that starts a flash cycle completes SETUP_CLKS+PULSE_CLKS+HOLD_CLKS+1 clocks after acceptance. An access without a flash cycle completes 1 clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 = register write, 0 = register read |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data: byte in 23:16, busy in 15 |
| host_ready | output | 1 | One-clock completion pulse |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Flash data bus, outgoing value |
| nand_dq_oe | output | 1 | Flash data bus drive enable |
| nand_dq_i | input | 8 | Flash data bus, incoming value |
| nand_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The bench first runs directed sequences that separate the three latch kinds: command, address and data write with enable set and with enable clear. These show whether the opcode field is decoded and whether the right latch line goes with each WE# pulse. Next come armed read streams, including a two-byte word read and reads after re-arming. These show whether each host read consumes exactly one flash byte in order, and whether disarmed reads stay silent and return the old byte. A long run of random opcodes from 0 to 7, random enable bits, random bytes and random numbers of reads follows. It catches errors in how chip enable, arming and strobe counts interact, while a timing monitor measures setup, pulse and hold on every strobe. The busy bit is sampled after one and after two clock edges to confirm the synchroniser depth.

// File: rtl/nand_bridge_pkg.sv
// Package: shared field positions, opcode values and sequencer phases for
// the register-mapped NAND bridge. Assumes a 32-bit host register.
package nand_bridge_pkg;

    localparam int REG_W       = 32;
    localparam int BYTE_W      = 8;
    localparam int EN_BIT      = 31;
    localparam int OP_HI       = 30;
    localparam int OP_LO       = 28;
    localparam int BYTE_LO     = 16;
    localparam int BUSY_BIT    = 15;

    localparam logic [2:0] OP_CMD   = 3'd0;
    localparam logic [2:0] OP_ADDR  = 3'd1;
    localparam logic [2:0] OP_READ  = 3'd2;
    localparam logic [2:0] OP_WRITE = 3'd3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } phase_t;

endpackage

// File: rtl/nand_rb_sync.sv
// Module: synchroniser for the asynchronous flash ready/busy pin.
// Assumes the pin is idle-high (ready); the chain resets to ready.
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_async,
    output logic busy
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flop chain, resetting to the ready level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rb_n_async};
        end
    end

    assign busy = ~chain_q[STAGES-1];

endmodule

// File: rtl/nand_strobe_seq.sv
// Module: timing sequencer for one flash strobe cycle (setup, pulse, hold).
// Assumes every count is at least 1 and that start arrives only when idle.
// Strobes are registered so the pins never glitch.
module nand_strobe_seq
    import nand_bridge_pkg::*;
#(
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_cycle,
    output logic we_n,
    output logic re_n,
    output logic active,
    output logic capture,
    output logic done
);

    localparam int MAX_A = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
    localparam int MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
    localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CLKS - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CLKS - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CLKS - 1);

    phase_t        phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rd_q;
    logic          we_n_q, re_n_q;

    // Next-phase and counter logic for the three timed phases.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q + CW'(1);
        unique case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (start) phase_d = PH_SETUP;
            end
            PH_SETUP: if (cnt_q == SETUP_LAST) begin
                phase_d = PH_PULSE;
                cnt_d   = '0;
            end
            PH_PULSE: if (cnt_q == PULSE_LAST) begin
                phase_d = PH_HOLD;
                cnt_d   = '0;
            end
            PH_HOLD: if (cnt_q == HOLD_LAST) begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase, counter, cycle kind and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            we_n_q  <= 1'b1;
            re_n_q  <= 1'b1;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            if (phase_q == PH_IDLE && start) rd_q <= rd_cycle;
            we_n_q  <= !(phase_d == PH_PULSE && !rd_q);
            re_n_q  <= !(phase_d == PH_PULSE && rd_q);
        end
    end

    assign we_n    = we_n_q;
    assign re_n    = re_n_q;
    assign active  = (phase_q != PH_IDLE);
    assign capture = (phase_q == PH_PULSE) && (cnt_q == PULSE_LAST) && rd_q;
    assign done    = (phase_q == PH_HOLD) && (cnt_q == HOLD_LAST);

    // R5: the two strobes are never low at the same time.
    p_strobes_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R5: a strobe is low only while the sequencer is in a cycle.
    p_strobe_in_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> active);

    // R11: done ends the cycle; the next clock is idle.
    p_done_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);

endmodule

// File: rtl/nand_rd_latch.sv
// Module: holds the last byte read from the flash bus.
// Assumes capture is high on the last pulse clock, while the flash drives data.
module nand_rd_latch
    import nand_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BYTE_W-1:0] dq_i,
    output logic [BYTE_W-1:0] byte_q
);

    // Sample the bus at the end of the read pulse, keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (capture) begin
            byte_q <= dq_i;
        end
    end

endmodule

// File: rtl/nand_reg_bridge.sv
// Module: top of the register-mapped NAND bridge. It decodes host accesses
// to the single register, drives latch lines and the data bus, starts strobe
// cycles, and answers the host with a one-clock ready pulse.
// Assumes the host holds the request stable until ready and drops it then.
module nand_reg_bridge
    import nand_bridge_pkg::*;
#(
    parameter int SETUP_CLKS = 2,
    parameter int PULSE_CLKS = 3,
    parameter int HOLD_CLKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_ready,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_i,
    input  logic        nand_rb_n
);

    logic [2:0]        op;
    logic              en_bit;
    logic [BYTE_W-1:0] wr_byte;
    logic              accept;
    logic              start_flash;
    logic              start_rd;
    logic              seq_active, seq_capture, seq_done;
    logic              busy;
    logic [BYTE_W-1:0] rd_byte;

    logic              ce_q, cle_q, ale_q, oe_q, armed_q, ack_q;
    logic [BYTE_W-1:0] dq_q;

    assign op      = host_wdata[OP_HI:OP_LO];
    assign en_bit  = host_wdata[EN_BIT];
    assign wr_byte = host_wdata[BYTE_LO +: BYTE_W];

    // Accept a request only when no cycle runs and no ack is pending.
    assign accept = host_req && !seq_active && !ack_q;

    // Decide whether the accepted access needs a flash strobe cycle.
    always_comb begin
        start_rd    = accept && !host_we && armed_q;
        start_flash = start_rd;
        if (accept && host_we) begin
            start_flash = (op == OP_CMD) || (op == OP_ADDR) ||
                          ((op == OP_WRITE) && en_bit);
        end
    end

    // Register decode: chip enable, arming, latch lines, bus drive and ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= 1'b0;
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            oe_q    <= 1'b0;
            dq_q    <= '0;
            armed_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (accept) begin
                if (host_we) begin
                    ce_q    <= en_bit;
                    armed_q <= (op == OP_READ);
                    if (start_flash) begin
                        cle_q <= (op == OP_CMD);
                        ale_q <= (op == OP_ADDR);
                        dq_q  <= wr_byte;
                        oe_q  <= 1'b1;
                    end else begin
                        ack_q <= 1'b1;
                    end
                end else if (!start_rd) begin
                    ack_q <= 1'b1;
                end
            end
            if (seq_done) begin
                cle_q <= 1'b0;
                ale_q <= 1'b0;
                oe_q  <= 1'b0;
                ack_q <= 1'b1;
            end
        end
    end

    nand_strobe_seq #(
        .SETUP_CLKS (SETUP_CLKS),
        .PULSE_CLKS (PULSE_CLKS),
        .HOLD_CLKS  (HOLD_CLKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_flash),
        .rd_cycle (start_rd),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .active   (seq_active),
        .capture  (seq_capture),
        .done     (seq_done)
    );

    nand_rd_latch u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (seq_capture),
        .dq_i    (nand_dq_i),
        .byte_q  (rd_byte)
    );

    nand_rb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_n_async (nand_rb_n),
        .busy       (busy)
    );

    assign nand_ce_n  = !ce_q;
    assign nand_cle   = cle_q;
    assign nand_ale   = ale_q;
    assign nand_dq_o  = dq_q;
    assign nand_dq_oe = oe_q;
    assign host_ready = ack_q;
    assign host_rdata = {8'h00, rd_byte, busy, 15'h0000};

    // R5: the two latch lines are never high together.
    p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R5: a write strobe always has the data bus driven.
    p_we_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);

    // R7: a read strobe begins only while read mode is armed.
    p_re_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> armed_q);

    // R11: ready is a single-clock pulse.
    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    // R5: the bus is not driven during a read cycle.
    p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

endmodule

// File: tb/tb_nand_reg_bridge.sv
// Bench: directed and seeded-random accesses against a small flash stub,
// with a strobe timing monitor. Expected values come from bench functions.
module tb_nand_reg_bridge;

    localparam int SETUP = 2;
    localparam int PULSE = 3;
    localparam int HOLD  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_i;
    logic        nand_rb_n = 1'b1;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // flash stub state
    int         we_count = 0;
    int         re_count = 0;
    logic       last_cle = 1'b0, last_ale = 1'b0;
    logic [7:0] last_dq = '0;

    // bench model
    int   exp_idx = 0;
    logic m_armed = 1'b0;
    logic m_ce = 1'b0;
    logic [7:0] m_last = '0;

    always #2 clk = ~clk;

    nand_reg_bridge #(
        .SETUP_CLKS (SETUP),
        .PULSE_CLKS (PULSE),
        .HOLD_CLKS  (HOLD)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_ready (host_ready),
        .nand_ce_n  (nand_ce_n),
        .nand_cle   (nand_cle),
        .nand_ale   (nand_ale),
        .nand_we_n  (nand_we_n),
        .nand_re_n  (nand_re_n),
        .nand_dq_o  (nand_dq_o),
        .nand_dq_oe (nand_dq_oe),
        .nand_dq_i  (nand_dq_i),
        .nand_rb_n  (nand_rb_n)
    );

    function automatic logic [7:0] flash_byte(input int idx);
        return 8'((idx * 37 + 5) & 255);
    endfunction

    function automatic logic [31:0] mk_wr(input logic en, input logic [2:0] op,
                                          input logic [7:0] b);
        return {en, op, 4'h0, b, 16'h0000};
    endfunction

    function automatic bit op_strobes(input logic [2:0] op, input logic en);
        return (op == 3'd0) || (op == 3'd1) || (op == 3'd3 && en);
    endfunction

    // flash stub: data presented from the read index, latched on WE# rise
    assign nand_dq_i = flash_byte(re_count);
    always @(posedge nand_we_n) if (rst_n) begin
        we_count++;
        last_cle = nand_cle;
        last_ale = nand_ale;
        last_dq  = nand_dq_o;
    end
    always @(posedge nand_re_n) if (rst_n) re_count++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "WDOG", "watchdog expired", cycles, 150000);
            finish_run();
        end
    end

    // timing monitor for R5: setup, pulse and hold of every strobe
    int pre = 0, low_we = 0, low_re = 0, post = 0;
    bit seen = 0;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (nand_dq_oe && nand_we_n && !seen) pre++;
        if (!nand_we_n) begin
            if (prev_we) chk(pre == SETUP, "R5", "setup clocks", pre, SETUP);
            low_we++;
            seen = 1;
        end else if (!prev_we) begin
            chk(low_we == PULSE, "R5", "WE pulse clocks", low_we, PULSE);
            low_we = 0;
        end
        if (!nand_re_n) low_re++;
        else if (!prev_re) begin
            chk(low_re == PULSE, "R5", "RE pulse clocks", low_re, PULSE);
            low_re = 0;
        end
        if (nand_dq_oe && nand_we_n && seen) post++;
        if (!nand_dq_oe && prev_oe) begin
            if (seen) chk(post == HOLD, "R5", "hold clocks", post, HOLD);
            pre = 0; post = 0; seen = 0;
        end
        if (nand_cle && nand_ale) chk(0, "R5", "CLE and ALE together", 1, 0);
        prev_we = nand_we_n;
        prev_re = nand_re_n;
        prev_oe = nand_dq_oe;
    end

    task automatic access(input logic we, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        host_we = we;
        host_wdata = wd;
        host_req = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!host_ready && cyc < 1000);
        rd = host_rdata;
        host_req = 1'b0;
        @(negedge clk);
        chk(!host_ready, "R11", "ready lasts one clock", host_ready, 0);
    endtask

    task automatic do_write(input logic en, input logic [2:0] op, input logic [7:0] b);
        logic [31:0] rd;
        int cyc;
        int w0;
        bit strobe;
        w0 = we_count;
        strobe = op_strobes(op, en);
        access(1'b1, mk_wr(en, op, b), rd, cyc);
        m_ce = en;
        m_armed = (op == 3'd2);
        chk(nand_ce_n == !en, "R2", "CE# after write", nand_ce_n, !en);
        chk(re_count >= 0 && cyc == (strobe ? SETUP + PULSE + HOLD + 1 : 1),
            "R11", "write latency", cyc, strobe ? SETUP + PULSE + HOLD + 1 : 1);
        if (strobe) begin
            chk(we_count == w0 + 1, op == 3'd3 ? "R6" : (op == 3'd0 ? "R3" : "R4"),
                "one WE pulse", we_count - w0, 1);
            chk(last_dq == b, "R3", "latched byte", last_dq, b);
            chk(last_cle == (op == 3'd0) && last_ale == (op == 3'd1),
                op == 3'd0 ? "R3" : (op == 3'd1 ? "R4" : "R6"),
                "latch lines", {last_cle, last_ale}, {op == 3'd0, op == 3'd1});
        end else begin
            chk(we_count == w0, op >= 3'd4 ? "R10" : (op == 3'd2 ? "R7" : "R6"),
                "no WE pulse", we_count - w0, 0);
        end
        chk(nand_dq_oe == 1'b0 && nand_cle == 1'b0 && nand_ale == 1'b0,
            "R5", "bus released after write", {nand_dq_oe, nand_cle, nand_ale}, 0);
    endtask

    task automatic do_read();
        logic [31:0] rd;
        int cyc;
        int r0;
        logic [7:0] exp_b;
        r0 = re_count;
        access(1'b0, 32'h0, rd, cyc);
        if (m_armed) begin
            exp_b = flash_byte(exp_idx);
            exp_idx++;
            m_last = exp_b;
            chk(re_count == r0 + 1, "R7", "one RE pulse", re_count - r0, 1);
            chk(rd[23:16] == exp_b, "R7", "streamed byte", rd[23:16], exp_b);
            chk(cyc == SETUP + PULSE + HOLD + 1, "R11", "read latency", cyc,
                SETUP + PULSE + HOLD + 1);
        end else begin
            chk(re_count == r0, "R8", "no RE pulse when disarmed", re_count - r0, 0);
            chk(rd[23:16] == m_last, "R8", "last byte kept", rd[23:16], m_last);
            chk(cyc == 1, "R11", "disarmed read latency", cyc, 1);
        end
        chk(rd[31:24] == 8'h00 && rd[14:0] == 15'h0, "R9", "unused bits zero",
            {rd[31:24], rd[14:0]}, 0);
    endtask

    initial begin
        int seed;
        seed = 32'h1234_abcd;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state during reset
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
            "R1", "pins in reset",
            {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 6'b111000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
            "R1", "pins after reset",
            {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 6'b111000);
        chk(host_rdata[15] == 1'b0, "R9", "ready after reset", host_rdata[15], 0);
        // R1: disarmed after reset, a read starts nothing
        do_read();

        // directed: command, address, data write with and without enable
        do_write(1'b1, 3'd0, 8'h70);
        do_write(1'b1, 3'd1, 8'h00);
        do_write(1'b1, 3'd1, 8'hA5);
        do_write(1'b1, 3'd3, 8'h3C);
        do_write(1'b0, 3'd3, 8'hC3);
        do_write(1'b0, 3'd0, 8'hFF);

        // R7: arm and stream a 16-bit word as two ordered bytes
        do_write(1'b1, 3'd2, 8'h00);
        do_read();
        do_read();
        // R8: any write disarms, then reads are silent
        do_write(1'b1, 3'd1, 8'h11);
        do_read();
        // R10: opcodes 4..7 only update CE, leave disarmed
        do_write(1'b1, 3'd2, 8'h00);
        do_write(1'b0, 3'd5, 8'h99);
        do_read();
        do_write(1'b1, 3'd7, 8'h42);

        // R9: busy through two stages
        nand_rb_n = 1'b0;
        @(negedge clk);
        chk(host_rdata[15] == 1'b0, "R9", "busy not yet after one edge", host_rdata[15], 0);
        @(negedge clk);
        chk(host_rdata[15] == 1'b1, "R9", "busy after two edges", host_rdata[15], 1);
        nand_rb_n = 1'b1;
        @(negedge clk);
        chk(host_rdata[15] == 1'b1, "R9", "still busy after one edge", host_rdata[15], 1);
        @(negedge clk);
        chk(host_rdata[15] == 1'b0, "R9", "ready after two edges", host_rdata[15], 0);

        // random mix of opcodes, enables, bytes and read counts
        for (int i = 0; i < 60; i++) begin
            logic [2:0] op;
            logic en;
            logic [7:0] b;
            int nrd;
            op  = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) op = 3'd2;
            en  = 1'($urandom_range(0, 1));
            b   = 8'($urandom_range(0, 255));
            nrd = $urandom_range(0, 3);
            do_write(en, op, b);
            for (int k = 0; k < nrd; k++) do_read();
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule